// File: doc/BRIEF.md
# D3cold Context Retention Controller

This controller sits beside a PCIe endpoint core, in logic that keeps auxiliary power and clock while main power is removed. When the core signals entry to the L2 link state, the controller records a 3-bit retention word. It records the word only if the management configuration says auxiliary power or PME-from-D3cold support is in use. It also records that the link is now resident in L2. An L2-exit pulse from the core, which the core gives only if it stayed powered, clears that residency.

If main power drops while the link is resident and later returns, the controller raises an exit request toward the core. It holds the request high until the core acknowledges it. While the request is high, the saved word is driven on the restore output. The acknowledge is synchronized into the auxiliary clock. The request is then released within a few clocks, well inside the 64-clock bound. Completing the handshake clears residency, so a later power cycle without a fresh L2 entry stays quiet.

The user's wake request is forwarded only when the retained PME-enable bit of the saved word is set.

Top module: `ctx_keeper`

## Requirements
- R1: After auxiliary reset, `exit_req`, `ctx_out` and `wake_out` are all 0.
- R2: With `main_pwr_ok` high and `retain_need` high, a cycle with `l2_enter` high stores `ctx_in`. Field order: bit 2 aux-power PM enable, bit 1 PME status, bit 0 PME enable. A later restore shows that value on `ctx_out`.
- R3: A cycle with `l2_enter` high while `retain_need` is 0 leaves the stored word unchanged but still marks the link resident.
- R4: An `l2_exit_pulse` while resident clears residency. A following power loss and restore raises no exit request.
- R5: `exit_req` stays 0 while `main_pwr_ok` is 0. It rises in the first cycle after `main_pwr_ok` is sampled high, if the link was resident when power fell.
- R6: Once high, `exit_req` stays high until the acknowledge has passed the 2-flop synchronizer. It then falls on the next clock: 3 clocks after `restore_ack` rises, and always fewer than 64.
- R7: While `exit_req` is high, `ctx_out` equals the word stored at the most recent qualifying L2 entry. Otherwise `ctx_out` is 0.
- R8: `wake_out` equals `wake_in` AND bit 0 (PME enable) of the stored word. When that bit is 0, wake is blocked in every state.
- R9: A completed handshake clears residency. A further power cycle with no new L2 entry raises no exit request.
- R10: `l2_enter` seen while `main_pwr_ok` is 0 is ignored: it neither stores the word nor marks residency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Auxiliary-domain clock |
| aux_rst_n | input | 1 | Auxiliary power-on reset, active low |
| retain_need | input | 1 | Configuration: aux power or PME-from-D3cold in use |
| main_pwr_ok | input | 1 | Main power present and core running |
| l2_enter | input | 1 | Core indicates L2 entry |
| l2_exit_pulse | input | 1 | Core one-clock pulse on L2 exit to L0 |
| ctx_in | input | 3 | Retention word from the core |
| restore_ack | input | 1 | Core acknowledge of exit request (asynchronous) |
| exit_req | output | 1 | Request to the core to restore context after D3cold |
| ctx_out | output | 3 | Restored retention word |
| wake_in | input | 1 | User wake request |
| wake_out | output | 1 | Gated wake request |

## Verification
The assertions take for granted that `main_pwr_ok`, `l2_enter` and `l2_exit_pulse` are already synchronous to the auxiliary clock. They also assume the core raises `restore_ack` only while `exit_req` is high and keeps it high until the request falls. The bench changes every input on the falling edge. It raises the acknowledge only after it has seen the request, and drops it once the request has fallen. It leaves the synchronizer several idle clocks to clear before the next power cycle.

// File: rtl/ctx_keeper.sv
module ctx_keeper #(
  parameter int W           = 3,
  parameter int PME_EN_BIT  = 0,
  parameter int SYNC_STAGES = 2,
  parameter int REL_LIMIT   = 64
) (
  input  logic         clk,
  input  logic         aux_rst_n,
  input  logic         retain_need,
  input  logic         main_pwr_ok,
  input  logic         l2_enter,
  input  logic         l2_exit_pulse,
  input  logic [W-1:0] ctx_in,
  input  logic         restore_ack,
  output logic         exit_req,
  output logic [W-1:0] ctx_out,
  input  logic         wake_in,
  output logic         wake_out
);

  localparam int CW = $clog2(REL_LIMIT + 1);

  typedef enum logic [1:0] {S_IDLE, S_L2, S_OFF, S_REQ} st_t;

  st_t              st, st_nx;
  logic [W-1:0]     saved;
  logic [SYNC_STAGES-1:0] ack_sync;
  logic             ack_s;
  logic [CW-1:0]    rel_cnt;

  assign ack_s    = ack_sync[SYNC_STAGES-1];
  assign exit_req = (st == S_REQ);
  assign ctx_out  = exit_req ? saved : '0;
  assign wake_out = wake_in & saved[PME_EN_BIT];

  always_ff @(posedge clk or negedge aux_rst_n) begin
    if (!aux_rst_n) ack_sync <= '0;
    else            ack_sync <= {ack_sync[SYNC_STAGES-2:0], restore_ack};
  end

  always_comb begin
    st_nx = st;
    unique case (st)
      S_IDLE: if (main_pwr_ok && l2_enter) st_nx = S_L2;
      S_L2: begin
        if (!main_pwr_ok)       st_nx = S_OFF;
        else if (l2_exit_pulse) st_nx = S_IDLE;
      end
      S_OFF:  if (main_pwr_ok) st_nx = S_REQ;
      S_REQ: begin
        if (!main_pwr_ok) st_nx = S_OFF;
        else if (ack_s)   st_nx = S_IDLE;
      end
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge aux_rst_n) begin
    if (!aux_rst_n) begin
      st    <= S_IDLE;
      saved <= '0;
    end else begin
      st <= st_nx;
      if (main_pwr_ok && l2_enter && retain_need && (st == S_IDLE || st == S_L2))
        saved <= ctx_in;
    end
  end

  always_ff @(posedge clk or negedge aux_rst_n) begin
    if (!aux_rst_n)                  rel_cnt <= '0;
    else if (!(exit_req && restore_ack)) rel_cnt <= '0;
    else if (rel_cnt != CW'(REL_LIMIT)) rel_cnt <= rel_cnt + 1'b1;
  end

  AST_REQ_AFTER_POWER: assert property (@(posedge clk) disable iff (!aux_rst_n)
    $rose(exit_req) |-> $past(main_pwr_ok)); // R5

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!aux_rst_n)
    (exit_req && !ack_s && main_pwr_ok) |=> exit_req); // R6

  AST_RELEASE_BOUND: assert property (@(posedge clk) disable iff (!aux_rst_n)
    rel_cnt < CW'(REL_LIMIT)); // R6

  AST_CTX_STEADY: assert property (@(posedge clk) disable iff (!aux_rst_n)
    (exit_req && $past(exit_req)) |-> $stable(ctx_out)); // R7

  AST_EXIT_CLEARS: assert property (@(posedge clk) disable iff (!aux_rst_n)
    (st == S_L2 && main_pwr_ok && l2_exit_pulse) |=> !exit_req); // R4

endmodule

// File: tb/ctx_keeper_tb.sv
module ctx_keeper_tb;
  logic clk = 0, aux_rst_n = 0;
  logic retain_need = 0, main_pwr_ok = 1, l2_enter = 0, l2_exit_pulse = 0;
  logic [2:0] ctx_in = '0;
  logic restore_ack = 0, wake_in = 0;
  logic exit_req, wake_out;
  logic [2:0] ctx_out;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ctx_keeper u_dut (.clk, .aux_rst_n, .retain_need, .main_pwr_ok, .l2_enter,
    .l2_exit_pulse, .ctx_in, .restore_ack, .exit_req, .ctx_out, .wake_in, .wake_out);

  // {need, word[2:0], exit_before_loss, exp_req, exp_word[2:0], exp_wake}
  localparam logic [9:0] VEC [0:5] = '{
    {1'b1, 3'd5, 1'b0, 1'b1, 3'd5, 1'b1},   // R2
    {1'b0, 3'd2, 1'b0, 1'b1, 3'd5, 1'b1},   // R3
    {1'b1, 3'd6, 1'b1, 1'b0, 3'd0, 1'b0},   // R4
    {1'b1, 3'd3, 1'b0, 1'b1, 3'd3, 1'b1},   // R2
    {1'b0, 3'd7, 1'b1, 1'b0, 3'd0, 1'b1},   // R3 R4
    {1'b1, 3'd0, 1'b0, 1'b1, 3'd0, 1'b0}    // R2 R8
  };

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic enter(logic need, logic [2:0] w);
    retain_need = need; ctx_in = w; l2_enter = 1;
    tick(1);
    l2_enter = 0;
  endtask

  task automatic power_cycle(logic exp_req, logic [2:0] exp_word, string tag);
    main_pwr_ok = 0;
    tick(3);
    chk({tag, " R5 low while off"}, {3'b0, exit_req}, 4'd0);
    main_pwr_ok = 1;
    tick(1);
    chk({tag, " R5 req after restore"}, {3'b0, exit_req}, {3'b0, exp_req});
    if (exp_req) begin
      chk({tag, " R7 word"}, {1'b0, ctx_out}, {1'b0, exp_word});
      restore_ack = 1;
      tick(2);
      chk({tag, " R6 hold"}, {3'b0, exit_req}, 4'd1);
      tick(1);
      chk({tag, " R6 release"}, {3'b0, exit_req}, 4'd0);
      chk({tag, " R7 zero idle"}, {1'b0, ctx_out}, 4'd0);
      restore_ack = 0;
      tick(4);
    end else begin
      tick(3);
      chk({tag, " R4 no req"}, {3'b0, exit_req}, 4'd0);
    end
  endtask

  initial begin
    tick(2);
    chk("R1 exit_req", {3'b0, exit_req}, 4'd0);
    chk("R1 ctx_out", {1'b0, ctx_out}, 4'd0);
    wake_in = 1; tick(1);
    chk("R1 wake_out", {3'b0, wake_out}, 4'd0);
    wake_in = 0;
    aux_rst_n = 1;
    tick(2);

    for (int v = 0; v < 6; v++) begin
      enter(VEC[v][9], VEC[v][8:6]);
      if (VEC[v][5]) begin l2_exit_pulse = 1; tick(1); l2_exit_pulse = 0; end
      power_cycle(VEC[v][4], VEC[v][3:1], $sformatf("vec%0d R2", v));
      wake_in = 1; tick(1);
      chk($sformatf("vec%0d R8 wake", v), {3'b0, wake_out}, {3'b0, VEC[v][0]});
      wake_in = 0; tick(1);
    end

    // R9: no fresh entry after completed handshake
    power_cycle(1'b0, 3'd0, "R9");

    // R10: entry while power off is ignored
    main_pwr_ok = 0; tick(1);
    enter(1'b1, 3'd1);
    tick(1);
    main_pwr_ok = 1; tick(1);
    chk("R10 no req", {3'b0, exit_req}, 4'd0);
    wake_in = 1; tick(1);
    chk("R10 word kept R8", {3'b0, wake_out}, 4'd0);
    wake_in = 0; tick(2);

    // R7: most recent of two entries wins
    enter(1'b1, 3'd1);
    enter(1'b1, 3'd4);
    power_cycle(1'b1, 3'd4, "R7 twice");
    wake_in = 1; tick(1);
    chk("R8 pme clear blocks", {3'b0, wake_out}, 4'd0);
    wake_in = 0; tick(1);

    enter(1'b1, 3'd7);
    wake_in = 1; tick(1);
    chk("R8 pme set passes", {3'b0, wake_out}, 4'd1);
    wake_in = 0; tick(1);
    chk("R8 no request no wake", {3'b0, wake_out}, 4'd0);
    power_cycle(1'b1, 3'd7, "R6 ack");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion"); end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule